// File: doc/BRIEF.md
# CAN Transmit Priority Reload Selector

This block decides which transmit message center feeds the single transmit buffer of a CAN controller. Each center has a ready bit, a direction bit and a data length code. A center whose frame is waiting to go out is called pending. The buffer is first loaded on a start request. After that it is loaded again every time the frame on the bus loses arbitration or hits an error. The block never simply retries the frame it already holds. Instead it picks again among every pending center, so a higher-priority frame that became ready in the meantime goes first, and no priority inversion occurs.

When a frame is sent successfully, its center is marked complete and the next pending center is loaded. If none is left, the buffer is released. The lowest center number always has the highest priority. The last center can only receive, so it is never a candidate. Sending bits on the bus and storing the buffer contents belong to other blocks. This block produces the selected index, a load strobe, a buffer-valid flag and the length of the selected frame.

Top module: `can_tx_reload_sel`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `load_stb`, `buf_valid`, `sel_idx` and `sel_len` are all 0.
- R2: With the buffer empty, a `start_req` pulse in cycle k makes `load_stb` high for exactly one cycle in cycle k+1. In that cycle `buf_valid` is 1 and `sel_idx` holds the lowest-numbered pending center.
- R3: A center is pending only when its `ctr_ready` bit is 1, its `ctr_dir_tx` bit is 1 (1 = transmit, 0 = receive) and it has not been marked complete. A center whose direction bit is 0 is never selected.
- R4: Center NUM_CTR-1 (index 14 by default) is receive-only and is never selected, whatever its ready and direction bits are.
- R5: While the buffer holds a frame, an `arb_lost` pulse in cycle k reloads the buffer in cycle k+1. The block picks again among the pending centers, including any that became ready after the previous load, and pulses `load_stb`.
- R6: While the buffer holds a frame, a `bus_error` pulse in cycle k reloads the buffer in cycle k+1, in the same way as R5.
- R7: A `tx_done` pulse in cycle k, while loaded, marks the selected center complete. In cycle k+1 the lowest remaining pending center is loaded, or, if none is left, `buf_valid` drops with no load pulse. A completed center becomes pending again only after its ready bit has been 0 for at least one cycle.
- R8: `sel_len` is captured at each load from the selected center's 4-bit length code, with codes above 8 reduced to 8. A later change to that code does not alter `sel_len` until the next load.
- R9: If nothing is pending, a request gives no load pulse, and `buf_valid` is 0 in the following cycle.
- R10: `arb_lost`, `bus_error` and `tx_done` have no effect while the buffer is empty, and `start_req` has no effect while it is loaded.
- R11: When `tx_done` arrives in the same cycle as `arb_lost` or `bus_error`, the completion takes precedence: the sent center is marked complete and is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctr_ready | input | NUM_CTR | Per-center ready bit |
| ctr_dir_tx | input | NUM_CTR | Per-center direction, 1 = transmit |
| ctr_dlc | input | 4*NUM_CTR | Per-center length code, center i at bits [4i+3:4i] |
| start_req | input | 1 | Initial load request |
| arb_lost | input | 1 | Bus arbitration lost for the buffered frame |
| bus_error | input | 1 | Error while sending the buffered frame |
| tx_done | input | 1 | Buffered frame sent successfully |
| load_stb | output | 1 | One-cycle pulse when the buffer is (re)loaded |
| buf_valid | output | 1 | Buffer holds a selected frame |
| sel_idx | output | clog2(NUM_CTR) | Selected center index |
| sel_len | output | 4 | Selected data length, 0 to 8 bytes |

## Verification
Every result is due exactly one clock edge after the cycle in which its event strobe or ready change is sampled. This holds for the load pulse, the new index, the captured length, the dropped valid flag and a completion mark. The bench drives inputs on the falling edge. A queue-free behavioural reference advances on the rising edge, and all four outputs are compared against it on the next falling edge, so both sides see the same sampled cycle. Directed checks read the outputs at that same falling edge, right after each strobe, to confirm the picks expected for the arbitration, error, completion, precedence and re-arm cases.

// File: rtl/can_txsel_pkg.sv
package can_txsel_pkg;
  localparam int DLC_W   = 4;
  localparam int MAX_LEN = 8;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  typedef enum logic {
    BUF_EMPTY  = 1'b0,
    BUF_LOADED = 1'b1
  } buf_state_e;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [DLC_W-1:0] code);
    if (int'(code) > MAX_LEN) return LEN_W'(MAX_LEN);
    else                      return LEN_W'(code);
  endfunction
endpackage

// File: rtl/can_txsel_pending.sv
module can_txsel_pending #(
  parameter int NUM_CTR = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] ready,
  input  logic [NUM_CTR-1:0] dir_tx,
  input  logic [NUM_CTR-1:0] sent,
  output logic [NUM_CTR-1:0] pending
);
  localparam logic [NUM_CTR-1:0] TX_CAPABLE = {1'b0, {(NUM_CTR-1){1'b1}}};

  logic [NUM_CTR-1:0] done_q;
  logic [NUM_CTR-1:0] done_d;
  logic [NUM_CTR-1:0] done_en;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    // completion flag: set by a successful send, cleared once ready drops
    assign done_en[g] = sent[g] | (done_q[g] & ~ready[g]);
    assign done_d[g]  = ready[g] & (done_q[g] | sent[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           done_q[g] <= 1'b0;
      else if (done_en[g])  done_q[g] <= done_d[g];
    end

    assert_sent_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sent[g] && ready[g]) |=> !pending[g])
      else $error("sent center %0d still pending", g);
  end

  assign pending = ready & dir_tx & ~done_q & TX_CAPABLE;
endmodule

// File: rtl/can_txsel_prio.sv
module can_txsel_prio #(
  parameter int NUM_CTR = 15,
  localparam int IDX_W  = $clog2(NUM_CTR)
) (
  input  logic [NUM_CTR-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_CTR-1:0] below_mask;

  // scan from the top so the lowest set bit is written last and wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_CTR - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CTR; i++) below_mask[i] = (i < int'(idx));
  end

  always_comb begin
    if (found) begin
      assert_lowest_first_R2: assert (req[idx] && ((req & below_mask) == '0))
        else $error("priority pick is not the lowest requester");
    end
  end
endmodule

// File: rtl/can_txsel_len_mux.sv
module can_txsel_len_mux
  import can_txsel_pkg::*;
#(
  parameter int NUM_CTR = 15,
  localparam int IDX_W  = $clog2(NUM_CTR)
) (
  input  logic [NUM_CTR*DLC_W-1:0] dlc_flat,
  input  logic [IDX_W-1:0]         idx,
  output logic [LEN_W-1:0]         len
);
  logic [DLC_W-1:0] dlc_arr [NUM_CTR];

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_unpack
    assign dlc_arr[g] = dlc_flat[g*DLC_W +: DLC_W];
  end

  always_comb begin
    if (int'(idx) < NUM_CTR) len = clamp_len(dlc_arr[idx]);
    else                     len = '0;
  end
endmodule

// File: rtl/can_tx_reload_sel.sv
module can_tx_reload_sel
  import can_txsel_pkg::*;
#(
  parameter int NUM_CTR = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CTR-1:0]            ctr_ready,
  input  logic [NUM_CTR-1:0]            ctr_dir_tx,
  input  logic [NUM_CTR*DLC_W-1:0]      ctr_dlc,
  input  logic                          start_req,
  input  logic                          arb_lost,
  input  logic                          bus_error,
  input  logic                          tx_done,
  output logic                          load_stb,
  output logic                          buf_valid,
  output logic [$clog2(NUM_CTR)-1:0]    sel_idx,
  output logic [LEN_W-1:0]              sel_len
);
  localparam int IDX_W = $clog2(NUM_CTR);
  localparam logic [IDX_W-1:0] RX_ONLY = IDX_W'(NUM_CTR - 1);

  buf_state_e         state_q, state_d;
  logic               load_q, load_d;
  logic [IDX_W-1:0]   sel_q, sel_d;
  logic [LEN_W-1:0]   len_q, len_d;

  logic [NUM_CTR-1:0] sent_vec;
  logic [NUM_CTR-1:0] pending;
  logic [NUM_CTR-1:0] cand;
  logic               pick_found;
  logic [IDX_W-1:0]   pick_idx;
  logic [LEN_W-1:0]   pick_len;
  logic               do_pick;

  // the center being reported as sent this cycle
  always_comb begin
    sent_vec = '0;
    if (state_q == BUF_LOADED && tx_done) sent_vec[sel_q] = 1'b1;
  end

  can_txsel_pending #(.NUM_CTR(NUM_CTR)) u_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (ctr_ready),
    .dir_tx  (ctr_dir_tx),
    .sent    (sent_vec),
    .pending (pending)
  );

  // the sent center is excluded in the same cycle its flag is being set
  assign cand = pending & ~sent_vec;

  can_txsel_prio #(.NUM_CTR(NUM_CTR)) u_prio (
    .req   (cand),
    .found (pick_found),
    .idx   (pick_idx)
  );

  can_txsel_len_mux #(.NUM_CTR(NUM_CTR)) u_len (
    .dlc_flat (ctr_dlc),
    .idx      (pick_idx),
    .len      (pick_len)
  );

  always_comb begin
    if (state_q == BUF_LOADED) do_pick = tx_done | arb_lost | bus_error;
    else                       do_pick = start_req;
  end

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    len_d   = len_q;
    load_d  = 1'b0;
    if (do_pick) begin
      if (pick_found) begin
        state_d = BUF_LOADED;
        load_d  = 1'b1;
        sel_d   = pick_idx;
        len_d   = pick_len;
      end else begin
        state_d = BUF_EMPTY;
        sel_d   = '0;
        len_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BUF_EMPTY;
      sel_q   <= '0;
      len_q   <= '0;
    end else if (do_pick) begin
      state_q <= state_d;
      sel_q   <= sel_d;
      len_q   <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= load_d;
  end

  assign load_stb  = load_q;
  assign buf_valid = (state_q == BUF_LOADED);
  assign sel_idx   = sel_q;
  assign sel_len   = len_q;

  assert_load_implies_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> buf_valid)
    else $error("load pulse without valid buffer");

  assert_load_was_tx_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> |(($past(ctr_dir_tx) >> sel_idx) & NUM_CTR'(1)))
    else $error("loaded a receive-direction center");

  assert_rx_only_excluded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (sel_idx != RX_ONLY))
    else $error("receive-only center selected");

  assert_arb_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && arb_lost && !tx_done) |=> (load_stb || !buf_valid))
    else $error("no reload after lost arbitration");

  assert_err_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && bus_error && !tx_done) |=> (load_stb || !buf_valid))
    else $error("no reload after bus error");

  assert_len_clamped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid |-> (int'(sel_len) <= MAX_LEN))
    else $error("selected length above limit");

  assert_load_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(start_req || arb_lost || bus_error || tx_done))
    else $error("load pulse without any event");
endmodule

// File: tb/can_tx_reload_sel_tb.sv
module can_tx_reload_sel_tb;
  import can_txsel_pkg::*;

  localparam int CLK_P = 10;
  localparam int N     = 15;
  localparam int IW    = $clog2(N);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      ctr_ready = '0;
  logic [N-1:0]      ctr_dir_tx = '0;
  logic [N*DLC_W-1:0] ctr_dlc = '0;
  logic              start_req = 1'b0;
  logic              arb_lost = 1'b0;
  logic              bus_error = 1'b0;
  logic              tx_done = 1'b0;
  logic              load_stb;
  logic              buf_valid;
  logic [IW-1:0]     sel_idx;
  logic [LEN_W-1:0]  sel_len;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";

  can_tx_reload_sel #(.NUM_CTR(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctr_ready(ctr_ready), .ctr_dir_tx(ctr_dir_tx),
    .ctr_dlc(ctr_dlc), .start_req(start_req), .arb_lost(arb_lost),
    .bus_error(bus_error), .tx_done(tx_done), .load_stb(load_stb),
    .buf_valid(buf_valid), .sel_idx(sel_idx), .sel_len(sel_len)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  bit m_done [N];
  bit m_valid = 0;
  bit m_load = 0;
  int m_sel = 0;
  int m_len = 0;

  always @(posedge clk or negedge rst_n) begin
    bit pend [N];
    bit sent, act;
    int pick, code;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_done[i] = 0;
      m_valid = 0; m_load = 0; m_sel = 0; m_len = 0;
    end else begin
      for (int i = 0; i < N; i++)
        pend[i] = ctr_ready[i] && ctr_dir_tx[i] && !m_done[i] && (i != N-1);
      sent = m_valid && tx_done;
      if (sent) pend[m_sel] = 0;
      act = m_valid ? (tx_done || arb_lost || bus_error) : start_req;
      for (int i = 0; i < N; i++)
        m_done[i] = ctr_ready[i] && (m_done[i] || (sent && i == m_sel));
      m_load = 0;
      if (act) begin
        pick = -1;
        for (int i = N-1; i >= 0; i--) if (pend[i]) pick = i;
        if (pick >= 0) begin
          code = int'(ctr_dlc[pick*DLC_W +: DLC_W]);
          m_valid = 1; m_load = 1; m_sel = pick;
          m_len = (code > MAX_LEN) ? MAX_LEN : code;
        end else begin
          m_valid = 0; m_sel = 0; m_len = 0;
        end
      end
    end
  end

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got=%0d exp=%0d", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("load_stb",  int'(load_stb),  int'(m_load));
    chk("buf_valid", int'(buf_valid), int'(m_valid));
    chk("sel_idx",   int'(sel_idx),   m_sel);
    chk("sel_len",   int'(sel_len),   m_len);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit s, input bit a, input bit e, input bit d);
    @(negedge clk);
    start_req = s; arb_lost = a; bus_error = e; tx_done = d;
    @(negedge clk);
    start_req = 0; arb_lost = 0; bus_error = 0; tx_done = 0;
  endtask

  task automatic set_ctr(input int i, input bit rdy, input bit tx, input int dlc);
    ctr_ready[i] = rdy;
    ctr_dir_tx[i] = tx;
    ctr_dlc[i*DLC_W +: DLC_W] = DLC_W'(dlc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R1";
    cyc(3);
    chk("reset load_stb R1", int'(load_stb), 0);
    chk("reset buf_valid R1", int'(buf_valid), 0);
    rst_n = 1'b1;
    cyc(2);
    chk("post-reset sel_idx R1", int'(sel_idx), 0);

    cur_req = "R9";
    strobe(1, 0, 0, 0);
    chk("empty start R9", int'(buf_valid), 0);

    cur_req = "R4";
    set_ctr(14, 1, 1, 5);
    strobe(1, 0, 0, 0);
    chk("rx-only center R4", int'(buf_valid), 0);

    cur_req = "R3";
    set_ctr(3, 1, 0, 2);
    set_ctr(5, 1, 1, 12);
    strobe(1, 0, 0, 0);
    chk("tx-dir pick R3", int'(sel_idx), 5);
    chk("load pulse R2", int'(load_stb), 1);
    cur_req = "R8";
    chk("clamped len R8", int'(sel_len), 8);
    cur_req = "R2";
    cyc(1);
    chk("pulse one cycle R2", int'(load_stb), 0);

    cur_req = "R10";
    set_ctr(5, 1, 1, 2);
    strobe(1, 0, 0, 0);
    chk("start while loaded R10", int'(load_stb), 0);
    cur_req = "R8";
    chk("len held R8", int'(sel_len), 8);

    cur_req = "R5";
    set_ctr(1, 1, 1, 3);
    strobe(0, 1, 0, 0);
    chk("arb reload idx R5", int'(sel_idx), 1);
    chk("arb reload len R5", int'(sel_len), 3);

    cur_req = "R6";
    set_ctr(0, 1, 1, 9);
    strobe(0, 0, 1, 0);
    chk("err reload idx R6", int'(sel_idx), 0);
    chk("err reload len R6", int'(sel_len), 8);

    cur_req = "R7";
    strobe(0, 0, 0, 1);
    chk("next after done R7", int'(sel_idx), 1);

    cur_req = "R11";
    strobe(0, 1, 0, 1);
    chk("done beats arb R11", int'(sel_idx), 5);
    chk("len of 5 R11", int'(sel_len), 2);

    cur_req = "R7";
    strobe(0, 0, 1, 1);
    chk("none left R7", int'(buf_valid), 0);
    chk("no pulse R7", int'(load_stb), 0);

    cur_req = "R10";
    strobe(0, 1, 0, 0);
    chk("arb while empty R10", int'(load_stb), 0);
    strobe(0, 0, 1, 1);
    chk("done while empty R10", int'(buf_valid), 0);

    cur_req = "R7";
    set_ctr(5, 0, 1, 4);
    cyc(1);
    set_ctr(5, 1, 1, 4);
    strobe(1, 0, 0, 0);
    chk("re-armed center R7", int'(sel_idx), 5);
    chk("re-armed len R7", int'(sel_len), 4);

    cur_req = "R2";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) begin
        int c;
        c = $urandom_range(N-1);
        set_ctr(c, ($urandom_range(3) != 0), ($urandom_range(4) != 0), $urandom_range(15));
      end
      start_req = ($urandom_range(5) == 0);
      arb_lost  = ($urandom_range(6) == 0);
      bus_error = ($urandom_range(9) == 0);
      tx_done   = ($urandom_range(4) == 0);
    end
    @(negedge clk);
    start_req = 0; arb_lost = 0; bus_error = 0; tx_done = 0;
    cyc(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule